// File: doc/BRIEF.md
# One-Byte Host Mailbox with Scratch-Mode Command Handshake

This block is the controller side of a byte-wide host mailbox patterned on the classic keyboard-controller handshake. The host sees two I/O addresses on an 8-bit bus. One is a data address, which is read to collect reply bytes. The other is a command/status address: the host writes command bytes to it and reads back a status byte. Each direction holds exactly one byte. The status byte reports whether the inbound byte has not yet been consumed and whether a reply is waiting.

Inside, a small controller takes each queued command after a fixed, parameterised latency, decodes it and changes the run mode between normal flash execution and scratch-RAM execution. Entry commands are answered with the acknowledge byte 0xFA. An exit command returns the controller to flash execution. An exit issued while already in flash mode raises a sticky system-reset request. A build parameter selects an alternate command set and its own port pair. That set has a second entry command that also arms a watchdog-reboot flag. A later exit with the flag armed clears the flag and requests a system reset.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, the mode output is flash (0), and the watchdog-reboot flag and system-reset request are both 0.
- R2: A read at the command/status address (0x64, or 0x66 when ALT_SET=1) returns the status byte, with inbound-full in bit 1, reply-full in bit 0 and bits 7:2 zero. The read has no side effect.
- R3: A write to the command/status address while inbound-full is 0 stores the byte and sets inbound-full at that clock edge. A write while inbound-full is 1 is dropped, so the byte already held is the one executed.
- R4: Inbound-full stays 1 for exactly TAKE_DELAY clock cycles after the accepting edge. It then clears as the controller takes the byte.
- R5: A read at the data address (0x60, or 0x62 when ALT_SET=1) returns the reply byte and clears reply-full at that edge.
- R6: An entry command (0xB4 when ALT_SET=0; 0xDD or 0xD8 when ALT_SET=1) taken in flash mode switches the mode to scratch (1), loads reply 0xFA and sets reply-full.
- R7: An entry command taken in scratch mode loads reply 0xFA and sets reply-full again. The mode, the watchdog-reboot flag and the reset request do not change.
- R8: An exit command (0xFE when ALT_SET=0, 0xFF when ALT_SET=1) taken in scratch mode with the watchdog-reboot flag clear returns the mode to flash. It posts no reply and does not raise the reset request.
- R9: An exit command taken in flash mode sets the system-reset request. The request stays 1 until reset, whatever commands follow.
- R10: With ALT_SET=1, entry command 0xD8 taken in flash mode also sets the watchdog-reboot flag. A later exit from scratch mode clears the flag, returns to flash and sets the system-reset request.
- R11: Any other command byte, including the entry and exit codes of the set not selected, is taken after the same latency and changes nothing else.
- R12: Writes to the data address and host accesses to any other address change neither the status nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status or reply byte) |
| scratch_mode | output | 1 | 1 while the controller runs from scratch RAM |
| wdt_reboot_flag | output | 1 | Watchdog-reboot flag armed by the flagged entry command |
| sys_reset_req | output | 1 | Sticky system-reset request |

## Verification
The assertions check on every cycle that an accepted command write sets inbound-full and that the take clears it. They also check that a data read with no command pending leaves reply-full clear, that every move into scratch mode carries a waiting 0xFA reply, that the watchdog-reboot flag is only ever set in scratch mode, and that a raised reset request never drops. Only the bench scenarios can show the exact length of the inbound-full window, that a write into a full inbound buffer is dropped, and that the re-entry acknowledge is repeated. They also cover unrecognised and foreign-set commands being swallowed and the two reset paths through the alternate command set.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;

  typedef enum logic {
    MODE_FLASH   = 1'b0,
    MODE_SCRATCH = 1'b1
  } run_mode_e;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_ENTER    = 2'd1,
    OP_ENTER_WD = 2'd2,
    OP_EXIT     = 2'd3
  } mbx_op_e;

  localparam int          ST_IBF_BIT = 1;
  localparam int          ST_OBF_BIT = 0;
  localparam logic [7:0]  ACK_BYTE   = 8'hFA;

  // Port pair of each command set.
  function automatic logic [15:0] data_port(input bit alt);
    return alt ? 16'h0062 : 16'h0060;
  endfunction

  function automatic logic [15:0] cmd_port(input bit alt);
    return alt ? 16'h0066 : 16'h0064;
  endfunction

endpackage

// File: rtl/kbc_reset_sync.sv
module kbc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/kbc_byte_buf.sv
module kbc_byte_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clear,
  output logic [W-1:0] data,
  output logic         full
);

  logic         full_d;
  logic [W-1:0] data_q;
  logic         full_q;

  // Loading wins over a clear in the same cycle.
  always_comb begin
    full_d = full_q;
    if (load)       full_d = 1'b1;
    else if (clear) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= load_data;
  end

  assign data = data_q;
  assign full = full_q;

endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_mbx_pkg::*;
#(
  parameter bit ALT_SET = 1'b0,
  parameter int ADDR_W  = 8
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              ibf,
  input  logic              obf,
  input  logic [7:0]        obuf_data,
  output logic              cmd_accept,
  output logic              data_read,
  output logic [7:0]        host_rdata
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(data_port(ALT_SET));
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(cmd_port(ALT_SET));

  logic hit_data;
  logic hit_cmd;
  logic [7:0] status;

  assign hit_data = (host_addr == DATA_ADDR);
  assign hit_cmd  = (host_addr == CMD_ADDR);

  // A write into a full inbound buffer is dropped.
  assign cmd_accept = host_wr && hit_cmd && !ibf;
  assign data_read  = host_rd && hit_data;

  always_comb begin
    status             = 8'h00;
    status[ST_IBF_BIT] = ibf;
    status[ST_OBF_BIT] = obf;
  end

  always_comb begin
    host_rdata = 8'h00;
    if (hit_cmd)       host_rdata = status;
    else if (hit_data) host_rdata = obuf_data;
  end

endmodule

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
  import kbc_mbx_pkg::*;
#(
  parameter bit ALT_SET    = 1'b0,
  parameter int TAKE_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ibf,
  input  logic [7:0] ibuf_data,
  output logic       take,
  output logic       post,
  output logic [7:0] post_data,
  output logic       scratch_mode,
  output logic       wdt_flag,
  output logic       sys_reset_req
);

  localparam int CNT_W = (TAKE_DELAY < 2) ? 1 : $clog2(TAKE_DELAY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TAKE_DELAY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  run_mode_e        mode_q, mode_d;
  logic             wdt_q, wdt_d;
  logic             rst_q, rst_d;
  mbx_op_e          op;

  // Command-set decoder chosen at build time.
  generate
    if (ALT_SET) begin : g_alt_set
      always_comb begin
        case (ibuf_data)
          8'hDD:   op = OP_ENTER;
          8'hD8:   op = OP_ENTER_WD;
          8'hFF:   op = OP_EXIT;
          default: op = OP_NONE;
        endcase
      end
    end else begin : g_std_set
      always_comb begin
        case (ibuf_data)
          8'hB4:   op = OP_ENTER;
          8'hFE:   op = OP_EXIT;
          default: op = OP_NONE;
        endcase
      end
    end
  endgenerate

  // Take latency counter.
  assign take   = ibf && (cnt_q == CNT_LAST);
  assign cnt_en = ibf || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (take || !ibf) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Command execution.
  always_comb begin
    mode_d = mode_q;
    wdt_d  = wdt_q;
    rst_d  = rst_q;
    post   = 1'b0;
    if (take) begin
      case (op)
        OP_ENTER: begin
          post = 1'b1;
          if (mode_q == MODE_FLASH) mode_d = MODE_SCRATCH;
        end
        OP_ENTER_WD: begin
          post = 1'b1;
          if (mode_q == MODE_FLASH) begin
            mode_d = MODE_SCRATCH;
            wdt_d  = 1'b1;
          end
        end
        OP_EXIT: begin
          if (mode_q == MODE_SCRATCH) begin
            mode_d = MODE_FLASH;
            if (wdt_q) begin
              rst_d = 1'b1;
              wdt_d = 1'b0;
            end
          end else begin
            rst_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FLASH;
      wdt_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else if (take) begin
      mode_q <= mode_d;
      wdt_q  <= wdt_d;
      rst_q  <= rst_d;
    end
  end

  assign post_data     = ACK_BYTE;
  assign scratch_mode  = (mode_q == MODE_SCRATCH);
  assign wdt_flag      = wdt_q;
  assign sys_reset_req = rst_q;

  // R4: the take empties the inbound buffer at that edge.
  a_r4_take_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ibf);

  // R9: a raised reset request never drops.
  a_r9_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  // R10: the watchdog-reboot flag is only held in scratch mode.
  a_r10_wdt_in_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_q |-> (mode_q == MODE_SCRATCH));

endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbx_pkg::*;
#(
  parameter bit ALT_SET    = 1'b0,
  parameter int TAKE_DELAY = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              scratch_mode,
  output logic              wdt_reboot_flag,
  output logic              sys_reset_req
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(data_port(ALT_SET));
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(cmd_port(ALT_SET));

  logic       rst_n_i;
  logic       ibf, obf;
  logic [7:0] ibuf_data, obuf_data;
  logic       cmd_accept, data_read;
  logic       take, post;
  logic [7:0] post_data;

  kbc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  kbc_host_port #(.ALT_SET(ALT_SET), .ADDR_W(ADDR_W)) u_port (
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .ibf        (ibf),
    .obf        (obf),
    .obuf_data  (obuf_data),
    .cmd_accept (cmd_accept),
    .data_read  (data_read),
    .host_rdata (host_rdata)
  );

  kbc_byte_buf #(.W(8)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (cmd_accept),
    .load_data (host_wdata),
    .clear     (take),
    .data      (ibuf_data),
    .full      (ibf)
  );

  kbc_byte_buf #(.W(8)) u_outbuf (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (post),
    .load_data (post_data),
    .clear     (data_read),
    .data      (obuf_data),
    .full      (obf)
  );

  kbc_cmd_ctrl #(.ALT_SET(ALT_SET), .TAKE_DELAY(TAKE_DELAY)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .ibf           (ibf),
    .ibuf_data     (ibuf_data),
    .take          (take),
    .post          (post),
    .post_data     (post_data),
    .scratch_mode  (scratch_mode),
    .wdt_flag      (wdt_reboot_flag),
    .sys_reset_req (sys_reset_req)
  );

  // R3: a command write into an empty inbound buffer fills it.
  a_r3_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n_i)
    (host_wr && host_addr == CMD_ADDR && !ibf) |=> ibf);

  // R5: a data read with no command pending leaves the reply empty.
  a_r5_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n_i)
    (host_rd && host_addr == DATA_ADDR && !ibf) |=> !obf);

  // R6: every move into scratch mode has an acknowledge waiting.
  a_r6_entry_acked: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(scratch_mode) |-> (obf && obuf_data == ACK_BYTE));

endmodule

// File: tb/kbc_mailbox_bench.sv
module kbc_mailbox_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TD         = 4;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk;
  logic       rst_n;
  logic [7:0] b_addr  [2];
  logic       b_wr    [2];
  logic       b_rd    [2];
  logic [7:0] b_wdata [2];
  logic [7:0] b_rdata [2];
  logic       b_mode  [2];
  logic       b_wdt   [2];
  logic       b_rst   [2];

  int n_checks;
  int n_fails;
  bit done;
  sb_item_t sb_q0[$];
  sb_item_t sb_q1[$];

  kbc_mailbox #(.ALT_SET(1'b0), .TAKE_DELAY(TD), .ADDR_W(8)) u_kbc_mailbox (
    .clk (clk), .rst_n (rst_n),
    .host_addr (b_addr[0]), .host_wr (b_wr[0]), .host_rd (b_rd[0]),
    .host_wdata (b_wdata[0]), .host_rdata (b_rdata[0]),
    .scratch_mode (b_mode[0]), .wdt_reboot_flag (b_wdt[0]),
    .sys_reset_req (b_rst[0])
  );

  kbc_mailbox #(.ALT_SET(1'b1), .TAKE_DELAY(TD), .ADDR_W(8)) u_kbc_mailbox_alt (
    .clk (clk), .rst_n (rst_n),
    .host_addr (b_addr[1]), .host_wr (b_wr[1]), .host_rd (b_rd[1]),
    .host_wdata (b_wdata[1]), .host_rdata (b_rdata[1]),
    .scratch_mode (b_mode[1]), .wdt_reboot_flag (b_wdt[1]),
    .sys_reset_req (b_rst[1])
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compare each read against the scoreboard in mid-cycle.
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (b_rd[d]) begin
        sb_item_t it;
        if (d == 0 && sb_q0.size() > 0) it = sb_q0.pop_front();
        else if (d == 1 && sb_q1.size() > 0) it = sb_q1.pop_front();
        else begin
          it.exp = 8'hxx;
          it.tag = "no expected item";
        end
        n_checks++;
        if (b_rdata[d] !== it.exp) begin
          n_fails++;
          $display("FAIL %s: dut%0d read actual 0x%02h expected 0x%02h",
                   it.tag, d, b_rdata[d], it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic host_write(input int d, input logic [7:0] a, input logic [7:0] v);
    b_addr[d]  = a;
    b_wdata[d] = v;
    b_wr[d]    = 1'b1;
    @(posedge clk);
    #1;
    b_wr[d]    = 1'b0;
  endtask

  task automatic host_read(input int d, input logic [7:0] a,
                           input logic [7:0] e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    if (d == 0) sb_q0.push_back(it);
    else        sb_q1.push_back(it);
    b_addr[d] = a;
    b_rd[d]   = 1'b1;
    @(posedge clk);
    #1;
    b_rd[d]   = 1'b0;
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    done = 1'b0;
    n_checks = 0;
    n_fails = 0;
    for (int d = 0; d < 2; d++) begin
      b_addr[d] = 8'h00; b_wr[d] = 1'b0; b_rd[d] = 1'b0; b_wdata[d] = 8'h00;
    end
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // ---------- default command set (ports 0x60 / 0x64) ----------
    host_read(0, 8'h64, 8'h00, "R1 reset status");
    check_bit("R1 reset mode", b_mode[0], 1'b0);
    check_bit("R1 reset wdt", b_wdt[0], 1'b0);
    check_bit("R1 reset sysreset", b_rst[0], 1'b0);

    // Entry: inbound-full window, then acknowledge.
    host_write(0, 8'h64, 8'hB4);
    host_read(0, 8'h64, 8'h02, "R2 R3 ibf set after write");
    idle(TD - 2);
    host_read(0, 8'h64, 8'h02, "R4 ibf still set in last cycle");
    host_read(0, 8'h64, 8'h01, "R4 ibf cleared, R6 obf set");
    check_bit("R6 mode scratch", b_mode[0], 1'b1);
    host_read(0, 8'h60, 8'hFA, "R6 ack byte");
    host_read(0, 8'h64, 8'h00, "R5 obf cleared by data read");

    // Re-entry in scratch.
    host_write(0, 8'h64, 8'hB4);
    idle(TD);
    host_read(0, 8'h64, 8'h01, "R7 re-entry obf set");
    host_read(0, 8'h60, 8'hFA, "R7 re-entry ack");
    check_bit("R7 mode unchanged", b_mode[0], 1'b1);
    check_bit("R7 sysreset unchanged", b_rst[0], 1'b0);

    // Dropped write while inbound is full; unknown command swallowed.
    host_write(0, 8'h64, 8'h00);
    host_write(0, 8'h64, 8'hFE);
    idle(TD);
    check_bit("R3 dropped exit left mode scratch", b_mode[0], 1'b1);
    host_read(0, 8'h64, 8'h00, "R11 unknown command no reply");

    // Exit from scratch.
    host_write(0, 8'h64, 8'hFE);
    idle(TD);
    check_bit("R8 mode back to flash", b_mode[0], 1'b0);
    check_bit("R8 no sysreset", b_rst[0], 1'b0);
    host_read(0, 8'h64, 8'h00, "R8 exit posts no reply");

    // Foreign-set entry code ignored.
    host_write(0, 8'h64, 8'hDD);
    idle(TD);
    check_bit("R11 foreign entry ignored", b_mode[0], 1'b0);
    host_read(0, 8'h64, 8'h00, "R11 foreign entry no reply");

    // Data-port write and stray address ignored.
    host_write(0, 8'h60, 8'hB4);
    host_read(0, 8'h64, 8'h00, "R12 data-port write ibf clear");
    host_write(0, 8'h70, 8'hB4);
    idle(TD);
    host_read(0, 8'h64, 8'h00, "R12 stray write status");
    check_bit("R12 mode unchanged", b_mode[0], 1'b0);

    // Exit while in flash: sticky reset request.
    host_write(0, 8'h64, 8'hFE);
    idle(TD);
    check_bit("R9 sysreset raised", b_rst[0], 1'b1);
    host_write(0, 8'h64, 8'hB4);
    idle(TD);
    host_read(0, 8'h60, 8'hFA, "R9 later entry still acked");
    check_bit("R9 sysreset sticky", b_rst[0], 1'b1);

    // ---------- alternate command set (ports 0x62 / 0x66) ----------
    host_read(1, 8'h66, 8'h00, "R1 alt reset status");
    host_write(1, 8'h66, 8'hB4);
    idle(TD);
    check_bit("R11 alt ignores default entry", b_mode[1], 1'b0);
    host_read(1, 8'h66, 8'h00, "R11 alt no reply");

    host_write(1, 8'h66, 8'hDD);
    idle(TD);
    check_bit("R6 alt entry mode", b_mode[1], 1'b1);
    check_bit("R6 alt entry no wdt", b_wdt[1], 1'b0);
    host_read(1, 8'h62, 8'hFA, "R6 alt ack");

    host_write(1, 8'h66, 8'hFF);
    idle(TD);
    check_bit("R8 alt exit mode", b_mode[1], 1'b0);
    check_bit("R8 alt exit no sysreset", b_rst[1], 1'b0);

    host_write(1, 8'h66, 8'hD8);
    idle(TD);
    check_bit("R10 flagged entry mode", b_mode[1], 1'b1);
    check_bit("R10 wdt armed", b_wdt[1], 1'b1);
    host_read(1, 8'h62, 8'hFA, "R10 flagged entry ack");

    host_write(1, 8'h66, 8'hD8);
    idle(TD);
    host_read(1, 8'h66, 8'h01, "R7 alt re-entry obf");
    host_read(1, 8'h62, 8'hFA, "R7 alt re-entry ack");
    check_bit("R7 alt wdt unchanged", b_wdt[1], 1'b1);
    check_bit("R7 alt mode unchanged", b_mode[1], 1'b1);

    host_write(1, 8'h66, 8'hFF);
    idle(TD);
    check_bit("R10 exit returns flash", b_mode[1], 1'b0);
    check_bit("R10 exit clears wdt", b_wdt[1], 1'b0);
    check_bit("R10 exit raises sysreset", b_rst[1], 1'b1);

    idle(2);
    n_checks++;
    if (sb_q0.size() + sb_q1.size() != 0) begin
      n_fails++;
      $display("FAIL R2 scoreboard: actual %0d pending expected 0",
               sb_q0.size() + sb_q1.size());
    end
    finish_run();
  end

endmodule